// File: doc/BRIEF.md
# Priority Microtask Scheduler

This block decides which of up to sixteen hardware microtasks owns a shared microcoded processor in each microinstruction cycle. Every task has a wakeup flag and a saved microprogram counter. Devices raise or drop a task's flag through per-task strobes. The running microinstruction can also give up the processor (yield) or put its own task to sleep (block). Task numbers double as priorities: when a switch is decided, the highest-numbered awake task wins. Task 0 is the background task and is always eligible to run.

A switch is never immediate. A yield captures the arbitration winner, and the processor moves to that task only after the next microinstruction, so the microcode gets one more instruction in the old task. While the current instruction waits on memory, every piece of state is held. The sequencer supplies a next address each cycle, and the scheduler writes it back into the running task's counter slot. Decode, the ALU and the devices sit outside the block and reach it only through input signals.

Top module: `micro_task_sched`

## Requirements
- R1: After reset, `cur_task` is 0, `task_awake` is 16'h0001, and every task's saved counter holds its own task number. A task that is first switched to therefore presents its number on `cur_pc`.
- R2: Arbitration picks the highest-numbered task whose wakeup flag is set. Bit i of `task_awake` is the flag of task i.
- R3: Bit 0 of `task_awake` is always 1. A sleep strobe or block request aimed at task 0 has no effect.
- R4: A cycle with `ui_yield` captures the winner of the flags as updated by that same cycle, including its block request. `cur_task` does not change at the end of that cycle.
- R5: A captured task becomes `cur_task` at the end of the next completed cycle that does not assert `ui_yield`. A further yield before then recaptures the winner and delays the switch again.
- R6: `ui_block` clears the flag of the running task. `dev_wake[i]` sets the flag of task i, and `dev_sleep[i]` clears it.
- R7: If a wake strobe and a sleep strobe or block request hit the same task in one cycle, the flag ends up set.
- R8: When `mem_op` is high and `mem_ready` is low, the cycle is suspended. Flags, counters, `cur_task` and any pending capture stay unchanged, and strobes and requests in that cycle are discarded.
- R9: `cur_pc` shows the running task's saved counter. Each completed cycle stores `next_pc` into that slot. A slot keeps its value while other tasks run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one microinstruction per cycle |
| rst | input | 1 | Synchronous active-high reset |
| dev_wake | input | 16 | Per-task wake strobes from devices |
| dev_sleep | input | 16 | Per-task sleep strobes from devices |
| ui_yield | input | 1 | Current microinstruction requests a task switch |
| ui_block | input | 1 | Current microinstruction puts its own task to sleep |
| mem_op | input | 1 | Current microinstruction uses memory |
| mem_ready | input | 1 | Memory can accept the operation this cycle |
| next_pc | input | 10 | Next address from the sequencer for the running task |
| cur_task | output | 4 | Number of the running task |
| cur_pc | output | 10 | Saved counter of the running task |
| task_awake | output | 16 | Wakeup flag of every task |

## Verification
Three kinds of update can land in the same cycle: a block request or sleep strobe and a wake strobe aimed at one task, a block and a yield together, and a stall on top of a yield plus strobes. The bench drives each combination in a single cycle. For the first, it checks `task_awake`. For the second, it checks which task runs two cycles later, which must be the next-highest task rather than the blocked one. For the stall, it checks that the flags, `cur_task` and `cur_pc` are unchanged. It then runs one ordinary cycle to confirm that the stalled yield was never captured.

// File: rtl/mts_pkg.sv
package mts_pkg;

    // Per-cycle control derived from the microinstruction and memory state
    typedef struct packed {
        logic advance;   // cycle completes (not stalled)
        logic yield;     // TASK request, effective only when advancing
        logic block;     // BLOCK request, effective only when advancing
    } cyc_ctl_t;

    function automatic cyc_ctl_t make_ctl(input logic yield_i, input logic block_i,
                                          input logic mem_op_i, input logic mem_ready_i);
        cyc_ctl_t c;
        c.advance = !(mem_op_i && !mem_ready_i);
        c.yield   = c.advance && yield_i;
        c.block   = c.advance && block_i;
        return c;
    endfunction

endpackage

// File: rtl/mts_wake_flags.sv
module mts_wake_flags #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] flags_nxt
);
    assign flags_nxt[0] = 1'b1;

    for (genvar i = 1; i < N; i++) begin : g_flag
        // wake strobe dominates clears
        assign flags_nxt[i] = set_vec[i] ? 1'b1 : (clr_vec[i] ? 1'b0 : flags_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)          flags_q <= N'(1);
        else if (advance) flags_q <= flags_nxt;
    end

    // R8
    stall_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(flags_q));

    // R3
    bg_task_awake_chk: assert property (@(posedge clk) disable iff (rst)
        $past(advance) |-> flags_q[0]);
endmodule

// File: rtl/mts_picker.sv
module mts_picker #(
    parameter int N  = 16,
    parameter int TW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [TW-1:0] sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) sel = TW'(i);
        end
    end
endmodule

// File: rtl/mts_pc_file.sv
module mts_pc_file #(
    parameter int N    = 16,
    parameter int PC_W = 10,
    parameter int TW   = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [TW-1:0]   wr_idx,
    input  logic [PC_W-1:0] wr_data,
    input  logic [TW-1:0]   rd_idx,
    output logic [PC_W-1:0] rd_data
);
    logic [PC_W-1:0] slot_q [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                               slot_q[i] <= PC_W'(i);
            else if (wr_en && wr_idx == TW'(i))    slot_q[i] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/micro_task_sched.sv
module micro_task_sched #(
    parameter int NUM_TASKS = 16,
    parameter int PC_W      = 10,
    localparam int TW       = $clog2(NUM_TASKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TASKS-1:0] dev_wake,
    input  logic [NUM_TASKS-1:0] dev_sleep,
    input  logic                 ui_yield,
    input  logic                 ui_block,
    input  logic                 mem_op,
    input  logic                 mem_ready,
    input  logic [PC_W-1:0]      next_pc,
    output logic [TW-1:0]        cur_task,
    output logic [PC_W-1:0]      cur_pc,
    output logic [NUM_TASKS-1:0] task_awake
);
    import mts_pkg::*;

    cyc_ctl_t             ctl;
    logic [TW-1:0]        cur_q;
    logic [TW-1:0]        pend_q;
    logic                 pend_vld_q;
    logic [TW-1:0]        win;
    logic [NUM_TASKS-1:0] flags_nxt;
    logic [NUM_TASKS-1:0] clr_vec;

    assign ctl     = make_ctl(ui_yield, ui_block, mem_op, mem_ready);
    assign clr_vec = dev_sleep | (ctl.block ? (NUM_TASKS'(1) << cur_q) : '0);

    mts_wake_flags #(.N(NUM_TASKS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .advance   (ctl.advance),
        .set_vec   (dev_wake),
        .clr_vec   (clr_vec),
        .flags_q   (task_awake),
        .flags_nxt (flags_nxt)
    );

    mts_picker #(.N(NUM_TASKS), .TW(TW)) u_pick (
        .req (flags_nxt),
        .sel (win)
    );

    mts_pc_file #(.N(NUM_TASKS), .PC_W(PC_W), .TW(TW)) u_pcs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl.advance),
        .wr_idx  (cur_q),
        .wr_data (next_pc),
        .rd_idx  (cur_q),
        .rd_data (cur_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (ctl.advance) begin
            if (ctl.yield) begin
                pend_q     <= win;
                pend_vld_q <= 1'b1;
            end else if (pend_vld_q) begin
                cur_q      <= pend_q;
                pend_vld_q <= 1'b0;
            end
        end
    end

    assign cur_task = cur_q;

    // R2
    win_is_highest_chk: assert property (@(posedge clk) disable iff (rst)
        flags_nxt[win] && ($countones(flags_nxt >> win) == 1));

    // R4
    yield_defers_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.yield |=> $stable(cur_task));

    // R5
    switch_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_vld_q |=> $stable(cur_task));

    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.advance |=> $stable(cur_task) && $stable(pend_vld_q) && $stable(cur_pc));

    // R9
    pc_writeback_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.advance && !pend_vld_q) |=> cur_pc == $past(next_pc));
endmodule

// File: tb/micro_task_sched_tb.sv
module micro_task_sched_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] dev_wake, dev_sleep;
    logic        ui_yield, ui_block, mem_op, mem_ready;
    logic [9:0]  next_pc;
    logic [3:0]  cur_task;
    logic [9:0]  cur_pc;
    logic [15:0] task_awake;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    micro_task_sched u_dut (
        .clk(clk), .rst(rst), .dev_wake(dev_wake), .dev_sleep(dev_sleep),
        .ui_yield(ui_yield), .ui_block(ui_block), .mem_op(mem_op),
        .mem_ready(mem_ready), .next_pc(next_pc), .cur_task(cur_task),
        .cur_pc(cur_pc), .task_awake(task_awake)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input int t, input int pc, input int aw);
        chk(req, "cur_task", int'(cur_task), t);
        chk(req, "cur_pc", int'(cur_pc), pc);
        chk(req, "task_awake", int'(task_awake), aw);
    endtask

    // one microinstruction: drive after negedge, sample at following negedge
    task automatic step(input logic [15:0] w, input logic [15:0] s, input logic y,
                        input logic b, input logic mop, input logic rdy, input logic [9:0] npc);
        dev_wake = w; dev_sleep = s; ui_yield = y; ui_block = b;
        mem_op = mop; mem_ready = rdy; next_pc = npc;
        @(posedge clk);
        @(negedge clk);
        dev_wake = '0; dev_sleep = '0; ui_yield = 1'b0; ui_block = 1'b0;
        mem_op = 1'b0; mem_ready = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        dev_wake = '0; dev_sleep = '0; ui_yield = 0; ui_block = 0;
        mem_op = 0; mem_ready = 1; next_pc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_state("R1", 0, 0, 16'h0001);
    endtask

    task automatic t_deferred_switch();
        step(16'h0020, 0, 0, 0, 0, 1, 10'h100);
        expect_state("R6", 0, 10'h100, 16'h0021);
        step(0, 0, 1, 0, 0, 1, 10'h101);
        expect_state("R4", 0, 10'h101, 16'h0021);
        step(0, 0, 0, 0, 0, 1, 10'h102);
        expect_state("R1", 5, 5, 16'h0021);       // fresh slot holds its number
    endtask

    task automatic t_repeated_yield();
        step(16'h0200, 0, 1, 0, 0, 1, 10'h200);
        expect_state("R4", 5, 10'h200, 16'h0221);
        step(0, 0, 1, 0, 0, 1, 10'h201);
        expect_state("R5", 5, 10'h201, 16'h0221);
        step(0, 0, 0, 0, 0, 1, 10'h202);
        expect_state("R5", 9, 9, 16'h0221);
    endtask

    task automatic t_priority();
        step(16'h1008, 0, 1, 0, 0, 1, 10'h300);
        step(0, 0, 0, 0, 0, 1, 10'h301);
        expect_state("R2", 12, 12, 16'h1229);
    endtask

    task automatic t_block_and_yield();
        step(0, 0, 1, 1, 0, 1, 10'h3c0);
        expect_state("R6", 12, 10'h3c0, 16'h0229);
        step(0, 0, 0, 0, 0, 1, 10'h3c1);
        expect_state("R4", 9, 10'h301, 16'h0229); // R9: slot of task 9 kept
    endtask

    task automatic t_wake_beats_block();
        step(16'h0200, 0, 0, 1, 0, 1, 10'h302);
        expect_state("R7", 9, 10'h302, 16'h0229);
    endtask

    task automatic t_stall();
        step(16'h4000, 16'h0008, 1, 0, 1, 0, 10'h3ff);
        expect_state("R8", 9, 10'h302, 16'h0229);
        step(0, 0, 0, 0, 0, 1, 10'h303);
        expect_state("R8", 9, 10'h303, 16'h0229); // stalled yield not captured
        step(0, 0, 0, 0, 1, 1, 10'h304);
        expect_state("R9", 9, 10'h304, 16'h0229);
    endtask

    task automatic t_background();
        step(0, 16'h022b, 1, 0, 0, 1, 10'h305);
        expect_state("R3", 9, 10'h305, 16'h0001);
        step(0, 0, 0, 0, 0, 1, 10'h306);
        expect_state("R9", 0, 10'h102, 16'h0001);
        step(0, 0, 1, 1, 0, 1, 10'h103);
        expect_state("R3", 0, 10'h103, 16'h0001);
        step(0, 0, 0, 0, 0, 1, 10'h104);
        expect_state("R3", 0, 10'h104, 16'h0001);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_deferred_switch();
                t_repeated_yield();
                t_priority();
                t_block_and_yield();
                t_wake_beats_block();
                t_stall();
                t_background();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule